// File: doc/BRIEF.md
# Two-Wire Debug Port Master

This block is the master side of a two-wire debug link to an 8051-style microcontroller's on-chip debugger. It owns three target pins: a debug clock, one data line shared by both directions (brought out as a driven value, an output enable and a sampled input) and an active-low target reset. On request it produces the sequence that puts the target into debug mode, the reset pulse that takes it out again, or a byte transfer made of a command phase followed by a response phase.

A host issues one operation at a time with a single-cycle `cmd_start`. A transfer carries a count of bytes to send, the bytes themselves and a count of bytes to read back. The block shifts each byte out most-significant bit first while driving the data line. It then releases the line to high impedance and shifts the response bytes in. It raises `done` for one cycle when the operation ends. The half-bit period of the debug clock is a whole number of system clock cycles, set by `HALF_DIV`. The meaning of command bytes is left to the host.

Top module: `dbg2w_master`

## Requirements
- R1: Out of reset, `dbg_clk`, `dbg_rst_n`, `dbg_dat_o` and `dbg_dat_oe` are all 1, and `busy` and `done` are 0.
- R2: An accepted `cmd_op` = 1 (enter) drives the clock low first. It then drives reset low, produces exactly two rising clock edges, returns the clock low and only then releases reset high. Each of these 7 phases lasts `HALF_DIV` cycles, so `done` rises 7*`HALF_DIV` cycles after acceptance and reset is low for 5*`HALF_DIV` cycles.
- R3: An accepted `cmd_op` = 2 (exit) holds the clock low and drives reset low for one bit period (2*`HALF_DIV` cycles), then releases it high and raises `done` 2*`HALF_DIV` cycles after acceptance.
- R4: With `cmd_op` = 0 (transfer), bytes are sent in order from `cmd_tx_data[7:0]` upward, each byte most-significant bit first. Each bit is set while the clock is low and is held stable for the whole high half.
- R5: The data line is driven (`dbg_dat_oe` = 1) during the command phase. It is released (`dbg_dat_oe` = 0) for the whole response phase and stays released after a transfer.
- R6: Each response bit is sampled in the last system cycle of the clock's high half. Response byte k lands in `rsp_data[8k+7:8k]`, most-significant bit first. Bytes above the requested count read as 0.
- R7: A transfer of T sent bytes and N read bytes raises `done` exactly 2*`HALF_DIV`*8*(T+N) cycles after acceptance.
- R8: A read count of 0 is allowed. The line is released and `done` rises right after the last sent bit. With both counts 0, `done` rises at the acceptance edge itself and `busy` never rises.
- R9: `busy` is 1 from the edge after acceptance until the operation ends. `done` is a single-cycle pulse and is never high together with `busy`.
- R10: `cmd_start` is ignored while `busy` is 1, and `cmd_op` = 3 is never accepted. Neither changes the pins or the ongoing operation.
- R11: A program-counter read (send the single byte 0x28, read 2 bytes) returns both response bytes in order.
- R12: A debug-instruction transfer of one command byte followed by 1, 2 or 3 instruction bytes reaches the target complete and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Single-cycle operation request |
| cmd_op | input | 2 | 0 transfer, 1 enter debug, 2 exit debug, 3 none |
| cmd_tx_cnt | input | $clog2(MAX_TX+1) | Bytes to send (clamped to MAX_TX) |
| cmd_tx_data | input | 8*MAX_TX | Bytes to send, first byte in bits 7:0 |
| cmd_rx_cnt | input | $clog2(MAX_RX+1) | Bytes to read back (clamped to MAX_RX) |
| rsp_data | output | 8*MAX_RX | Captured response bytes, first byte in bits 7:0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| dbg_clk | output | 1 | Debug clock to the target |
| dbg_rst_n | output | 1 | Active-low target reset |
| dbg_dat_o | output | 1 | Value driven onto the shared data line |
| dbg_dat_oe | output | 1 | Drive enable for the shared data line |
| dbg_dat_i | input | 1 | Value sampled from the shared data line |

## Verification
The assertions take for granted that `cmd_op`, the counts and the send data are valid in the cycle `cmd_start` is high, that the counts do not exceed the maximums, and that the target settles `dbg_dat_i` within one system cycle of a rising debug clock, which needs `HALF_DIV` of at least 2. The bench keeps to this. Its target model answers on the rising edge it observes. It draws random send counts from 1 to the maximum and read counts from 0 to the maximum, and it holds the request fields steady around each start. Directed cases add the enter and exit sequences, the program-counter read, each debug-instruction length, zero-length reads, and requests made while busy or with the unused code.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;

  typedef enum logic [1:0] {
    OP_XFER  = 2'd0,
    OP_ENTER = 2'd1,
    OP_EXIT  = 2'd2,
    OP_NONE  = 2'd3
  } dbg2w_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ENTER,
    S_EXIT,
    S_TXLO,
    S_TXHI,
    S_RXLO,
    S_RXHI
  } dbg2w_state_e;

  localparam logic [2:0] ENTER_LAST_STEP = 3'd6;

  // debug clock level for each half-bit step of the entry sequence
  function automatic logic enter_clk(input logic [2:0] step);
    return (step == 3'd2) || (step == 3'd4);
  endfunction

  // reset level for each half-bit step of the entry sequence
  function automatic logic enter_rst_n(input logic [2:0] step);
    return (step == 3'd0) || (step == 3'd6);
  endfunction

  // serial bit index -> vector position (byte order ascending, MSB first)
  function automatic logic [15:0] bit_slot(input logic [15:0] idx);
    return {idx[15:3], ~idx[2:0]};
  endfunction

endpackage

// File: rtl/dbg2w_halftimer.sv
module dbg2w_halftimer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic half_end
);
  localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !run)   cnt <= '0;
    else if (half_end)          cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  assign half_end = run && (cnt == LAST);

  // R7: the half-bit counter never leaves its range
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/dbg2w_bitbuf.sv
module dbg2w_bitbuf #(
  parameter int MAX_TX = 4,
  parameter int MAX_RX = 4,
  parameter int TXW    = 6,
  parameter int RXW    = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [MAX_TX*8-1:0]   tx_in,
  input  logic [TXW-1:0]        tx_idx,
  output logic                  tx_bit,
  input  logic                  cap_en,
  input  logic [RXW-1:0]        cap_idx,
  input  logic                  cap_bit,
  input  logic                  line_high,
  output logic [MAX_RX*8-1:0]   rx_out
);
  import dbg2w_pkg::*;

  localparam int TIW = $clog2(MAX_TX * 8);
  localparam int RIW = $clog2(MAX_RX * 8);

  logic [MAX_TX*8-1:0] tx_vec;
  logic [MAX_RX*8-1:0] rx_vec;
  logic [15:0]         tslot;
  logic [15:0]         rslot;

  assign tslot  = bit_slot(16'(tx_idx));
  assign rslot  = bit_slot(16'(cap_idx));
  assign tx_bit = tx_vec[tslot[TIW-1:0]];
  assign rx_out = rx_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_vec <= '0;
      rx_vec <= '0;
    end else if (load) begin
      tx_vec <= tx_in;
      rx_vec <= '0;
    end else if (cap_en) begin
      rx_vec[rslot[RIW-1:0]] <= cap_bit;
    end
  end

  // R6: a response bit is taken only while the debug clock is high
  p_capture_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> line_high);

  // R6: loading and capturing never coincide
  p_load_cap_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && cap_en));

endmodule

// File: rtl/dbg2w_master.sv
module dbg2w_master #(
  parameter int HALF_DIV = 4,
  parameter int MAX_TX   = 4,
  parameter int MAX_RX   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_start,
  input  logic [1:0]                   cmd_op,
  input  logic [$clog2(MAX_TX+1)-1:0]  cmd_tx_cnt,
  input  logic [MAX_TX*8-1:0]          cmd_tx_data,
  input  logic [$clog2(MAX_RX+1)-1:0]  cmd_rx_cnt,
  output logic [MAX_RX*8-1:0]          rsp_data,
  output logic                         busy,
  output logic                         done,
  output logic                         dbg_clk,
  output logic                         dbg_rst_n,
  output logic                         dbg_dat_o,
  output logic                         dbg_dat_oe,
  input  logic                         dbg_dat_i
);
  import dbg2w_pkg::*;

  localparam int TCW = $clog2(MAX_TX + 1);
  localparam int RCW = $clog2(MAX_RX + 1);
  localparam int TXW = TCW + 3;
  localparam int RXW = RCW + 3;

  function automatic logic [TCW-1:0] clamp_tx(input logic [TCW-1:0] n);
    return (n > TCW'(MAX_TX)) ? TCW'(MAX_TX) : n;
  endfunction

  function automatic logic [RCW-1:0] clamp_rx(input logic [RCW-1:0] n);
    return (n > RCW'(MAX_RX)) ? RCW'(MAX_RX) : n;
  endfunction

  dbg2w_state_e   state;
  logic [2:0]     step;
  logic [TXW-1:0] tx_idx, tx_nbits, req_tx_bits;
  logic [RXW-1:0] rx_idx, rx_nbits, req_rx_bits;
  logic           clk_q, rst_q, dat_q, oe_q, done_q;

  // named internal events
  logic accept, half_end, load_buf, cap_en, next_tx_bit;
  logic tx_last, rx_last, in_rx;

  assign accept      = cmd_start && (state == S_IDLE) && (cmd_op != OP_NONE);
  assign load_buf    = accept && (cmd_op == OP_XFER);
  assign req_tx_bits = {clamp_tx(cmd_tx_cnt), 3'b000};
  assign req_rx_bits = {clamp_rx(cmd_rx_cnt), 3'b000};
  assign tx_last     = (tx_idx == tx_nbits - 1'b1);
  assign rx_last     = (rx_idx == rx_nbits - 1'b1);
  assign cap_en      = (state == S_RXHI) && half_end;
  assign in_rx       = (state == S_RXLO) || (state == S_RXHI);

  dbg2w_halftimer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .restart  (accept),
    .half_end (half_end)
  );

  dbg2w_bitbuf #(.MAX_TX(MAX_TX), .MAX_RX(MAX_RX), .TXW(TXW), .RXW(RXW)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_buf),
    .tx_in     (cmd_tx_data),
    .tx_idx    (tx_idx + 1'b1),
    .tx_bit    (next_tx_bit),
    .cap_en    (cap_en),
    .cap_idx   (rx_idx),
    .cap_bit   (dbg_dat_i),
    .line_high (clk_q),
    .rx_out    (rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      step     <= '0;
      tx_idx   <= '0;
      rx_idx   <= '0;
      tx_nbits <= '0;
      rx_nbits <= '0;
      clk_q    <= 1'b1;
      rst_q    <= 1'b1;
      dat_q    <= 1'b1;
      oe_q     <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            clk_q <= 1'b0;
            step  <= '0;
            case (cmd_op)
              OP_ENTER: begin
                dat_q <= 1'b1;
                oe_q  <= 1'b1;
                state <= S_ENTER;
              end
              OP_EXIT: begin
                rst_q <= 1'b0;
                state <= S_EXIT;
              end
              default: begin
                tx_idx   <= '0;
                rx_idx   <= '0;
                tx_nbits <= req_tx_bits;
                rx_nbits <= req_rx_bits;
                if (req_tx_bits != '0) begin
                  oe_q  <= 1'b1;
                  dat_q <= cmd_tx_data[7];
                  state <= S_TXLO;
                end else begin
                  oe_q <= 1'b0;
                  if (req_rx_bits != '0) state <= S_RXLO;
                  else                   done_q <= 1'b1;
                end
              end
            endcase
          end
        end
        S_ENTER: begin
          if (half_end) begin
            if (step == ENTER_LAST_STEP) begin
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              step  <= step + 3'd1;
              clk_q <= enter_clk(step + 3'd1);
              rst_q <= enter_rst_n(step + 3'd1);
            end
          end
        end
        S_EXIT: begin
          if (half_end) begin
            if (step == 3'd1) begin
              rst_q  <= 1'b1;
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              step <= 3'd1;
            end
          end
        end
        S_TXLO: begin
          if (half_end) begin
            clk_q <= 1'b1;
            state <= S_TXHI;
          end
        end
        S_TXHI: begin
          if (half_end) begin
            clk_q <= 1'b0;
            if (tx_last) begin
              oe_q <= 1'b0;
              if (rx_nbits != '0) state <= S_RXLO;
              else begin
                done_q <= 1'b1;
                state  <= S_IDLE;
              end
            end else begin
              tx_idx <= tx_idx + 1'b1;
              dat_q  <= next_tx_bit;
              state  <= S_TXLO;
            end
          end
        end
        S_RXLO: begin
          if (half_end) begin
            clk_q <= 1'b1;
            state <= S_RXHI;
          end
        end
        S_RXHI: begin
          if (half_end) begin
            clk_q <= 1'b0;
            if (rx_last) begin
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              rx_idx <= rx_idx + 1'b1;
              state  <= S_RXLO;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign done       = done_q;
  assign dbg_clk    = clk_q;
  assign dbg_rst_n  = rst_q;
  assign dbg_dat_o  = dat_q;
  assign dbg_dat_oe = oe_q;

  // R9: the end pulse only appears once the block is idle again
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4: the driven bit never moves during a high half
  p_dat_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dbg_dat_oe && $past(dbg_dat_oe) && dbg_clk && $past(dbg_clk))
      |-> $stable(dbg_dat_o));

  // R5: the line is released for the whole response phase
  p_rx_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_rx |-> !dbg_dat_oe);

  // R2, R3: reset is always released with the debug clock low
  p_rst_release_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_rst_n) |-> !dbg_clk);

  // R10: a request during the entry sequence does not divert it
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && state == S_ENTER) |=> (state == S_ENTER || state == S_IDLE));

  // R10: the unused code never starts anything from idle
  p_none_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && cmd_start && cmd_op == OP_NONE) |=> !busy);

endmodule

// File: tb/sim_dbg2w_master.sv
module sim_dbg2w_master;
  localparam int H   = 4;
  localparam int MT  = 4;
  localparam int MR  = 4;
  localparam int TCW = $clog2(MT + 1);
  localparam int RCW = $clog2(MR + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_start = 1'b0;
  logic [1:0]      cmd_op = 2'd0;
  logic [TCW-1:0]  cmd_tx_cnt = '0;
  logic [MT*8-1:0] cmd_tx_data = '0;
  logic [RCW-1:0]  cmd_rx_cnt = '0;
  logic [MR*8-1:0] rsp_data;
  logic            busy, done;
  logic            dbg_clk, dbg_rst_n, dbg_dat_o, dbg_dat_oe;
  logic            dbg_dat_i = 1'b0;

  always #10 clk = ~clk;

  dbg2w_master #(.HALF_DIV(H), .MAX_TX(MT), .MAX_RX(MR)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_tx_cnt(cmd_tx_cnt), .cmd_tx_data(cmd_tx_data), .cmd_rx_cnt(cmd_rx_cnt),
    .rsp_data(rsp_data), .busy(busy), .done(done),
    .dbg_clk(dbg_clk), .dbg_rst_n(dbg_rst_n), .dbg_dat_o(dbg_dat_o),
    .dbg_dat_oe(dbg_dat_oe), .dbg_dat_i(dbg_dat_i)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] resp_fn(input logic [7:0] c, input int k);
    return c ^ (8'h5A + 8'(k * 37));
  endfunction

  // ---------------- target model ----------------
  logic       tgt_clr = 1'b1;
  logic       pc = 1'b1, pr = 1'b1;
  logic [7:0] rcv [0:7];
  int         rcv_n, sh_n, resp_bit, edges, low_cnt, low_len, rst_falls;
  logic [7:0] shreg, rb;
  logic       fell_clk, ent_ok, ent_seen;

  always @(negedge clk) begin
    if (tgt_clr) begin
      rcv_n = 0; sh_n = 0; resp_bit = 0; edges = 0; low_cnt = 0; low_len = 0;
      rst_falls = 0; shreg = 8'h00; fell_clk = 1'b1; ent_ok = 1'b0;
      ent_seen = 1'b0; dbg_dat_i = 1'b0;
      for (int i = 0; i < 8; i++) rcv[i] = 8'h00;
    end else begin
      if (pr && !dbg_rst_n) begin
        fell_clk = dbg_clk; edges = 0; low_cnt = 0; rst_falls++;
      end
      if (!dbg_rst_n) begin
        low_cnt++;
        if (!pc && dbg_clk) edges++;
      end
      if (!pr && dbg_rst_n) begin
        ent_seen = 1'b1;
        ent_ok   = !fell_clk && (edges == 2) && !dbg_clk;
        low_len  = low_cnt;
      end
      if (!pc && dbg_clk && dbg_rst_n) begin
        if (dbg_dat_oe) begin
          shreg = {shreg[6:0], dbg_dat_o};
          sh_n++;
          if (sh_n == 8) begin
            if (rcv_n < 8) rcv[rcv_n] = shreg;
            rcv_n++;
            sh_n = 0;
          end
        end else begin
          rb = resp_fn(rcv[0], resp_bit / 8);
          dbg_dat_i = rb[7 - (resp_bit % 8)];
          resp_bit++;
        end
      end
    end
    pc = dbg_clk;
    pr = dbg_rst_n;
  end

  task automatic clear_target();
    @(negedge clk); tgt_clr = 1'b1;
    @(negedge clk); tgt_clr = 1'b0;
  endtask

  // issues one request; returns cycles from acceptance edge to done
  int  cyc;
  bit  busy_seen;
  task automatic run_op(input logic [1:0] op, input int ntx,
                        input logic [MT*8-1:0] txd, input int nrx);
    @(negedge clk);
    cmd_op = op; cmd_tx_cnt = TCW'(ntx); cmd_tx_data = txd; cmd_rx_cnt = RCW'(nrx);
    cmd_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_start = 1'b0;
    cyc = 0;
    busy_seen = busy;
    while (!done && cyc < 3000) begin
      @(posedge clk); @(negedge clk);
      cyc++;
      if (busy) busy_seen = 1'b1;
    end
    @(posedge clk); @(negedge clk);
    check(!done, "R9 done single pulse", done, 0);
  endtask

  // watchdog
  initial begin
    #(100000 * 20);
    n_err++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  task automatic check_xfer(input int ntx, input logic [MT*8-1:0] txd, input int nrx,
                            input string tag);
    check(rcv_n == ntx, {tag, " byte count"}, rcv_n, ntx);
    for (int i = 0; i < ntx; i++)
      check(rcv[i] == txd[8*i +: 8], {tag, " R4 sent byte"}, rcv[i], txd[8*i +: 8]);
    for (int k = 0; k < MR; k++) begin
      logic [7:0] e;
      e = (k < nrx) ? resp_fn(txd[7:0], k) : 8'h00;
      check(rsp_data[8*k +: 8] == e, {tag, " R6 response byte"}, rsp_data[8*k +: 8], e);
    end
    check(cyc == 2*H*8*(ntx+nrx), {tag, " R7 duration"}, cyc, 2*H*8*(ntx+nrx));
    check(dbg_dat_oe == 1'b0, {tag, " R5 line released"}, dbg_dat_oe, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tgt_clr = 1'b0;
    // R1 reset state
    check(dbg_clk && dbg_rst_n && dbg_dat_o && dbg_dat_oe,
          "R1 pins high", {dbg_clk, dbg_rst_n, dbg_dat_o, dbg_dat_oe}, 4'hF);
    check(!busy && !done, "R1 busy/done low", {busy, done}, 0);

    // R2 entry sequence
    run_op(2'd1, 0, '0, 0);
    check(ent_seen && ent_ok, "R2 entry shape", {ent_seen, ent_ok}, 2'b11);
    check(cyc == 7*H, "R2 entry duration", cyc, 7*H);
    check(low_len == 5*H, "R2 reset low time", low_len, 5*H);
    check(busy_seen, "R9 busy during entry", busy_seen, 1);

    // R11 program-counter read
    clear_target();
    run_op(2'd0, 1, 32'h0000_0028, 2);
    check_xfer(1, 32'h0000_0028, 2, "R11");

    // R12 debug instruction with 1..3 instruction bytes
    for (int n = 1; n <= 3; n++) begin
      logic [MT*8-1:0] d;
      d = {8'hE4, 8'h90, 8'h12, 8'h55};
      clear_target();
      run_op(2'd0, n + 1, d, 1);
      check_xfer(n + 1, d, 1, "R12");
    end

    // R8 send only, zero read
    clear_target();
    run_op(2'd0, 2, 32'h0000_A3C1, 0);
    check_xfer(2, 32'h0000_A3C1, 0, "R8 zero read");

    // R8 nothing at all
    clear_target();
    run_op(2'd0, 0, '0, 0);
    check(cyc == 0, "R8 empty done at acceptance", cyc, 0);
    check(!busy_seen, "R8 empty never busy", busy_seen, 0);
    check(dbg_dat_oe == 1'b0, "R8 empty releases line", dbg_dat_oe, 0);

    // R10 unused code from idle
    clear_target();
    @(negedge clk);
    cmd_op = 2'd3; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    check(!busy && !done, "R10 op3 ignored", {busy, done}, 0);
    check(dbg_rst_n && !dbg_dat_oe, "R10 op3 pins unchanged", {dbg_rst_n, dbg_dat_oe}, 2'b10);

    // R10 request while busy
    clear_target();
    fork
      run_op(2'd0, 2, 32'h0000_7E81, 2);
      begin
        repeat (30) @(negedge clk);
        cmd_op = 2'd2; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; cmd_op = 2'd0;
      end
    join
    check(rst_falls == 0, "R10 no reset pulse while busy", rst_falls, 0);
    check_xfer(2, 32'h0000_7E81, 2, "R10 busy request");

    // random transfers
    for (int t = 0; t < 25; t++) begin
      int ntx, nrx;
      logic [MT*8-1:0] d;
      ntx = 1 + int'($urandom_range(MT - 1));
      nrx = int'($urandom_range(MR));
      d = {$urandom, $urandom};
      clear_target();
      run_op(2'd0, ntx, d, nrx);
      check_xfer(ntx, d, nrx, "R4 R6 R7 random");
    end

    // R3 exit
    clear_target();
    run_op(2'd2, 0, '0, 0);
    check(cyc == 2*H, "R3 exit duration", cyc, 2*H);
    check(low_len == 2*H, "R3 reset low one bit", low_len, 2*H);
    check(dbg_rst_n == 1'b1, "R3 reset released", dbg_rst_n, 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule